// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block gathers the per-channel events of a multi-channel DMA engine into status registers and a single interrupt line. Each channel reports a transfer-done pulse, a suspended pulse and eight error-class pulses. A per-channel latch mask decides which of these pulses are recorded. A separate per-channel signal mask decides which recorded bits may drive the interrupt. An event can therefore be recorded for polling without raising the interrupt line.

Software reaches the block through a simple 32-bit register port with word-aligned byte addresses. The port has one global configuration word. Each channel has a block of four words: latch mask, signal mask, read-only status, and a write-one-to-clear word. Read data is registered and is valid on the cycle after the read strobe. The interrupt output is registered. It is the OR, over all channels, of status ANDed with the signal mask, gated by the global interrupt enable.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, every mask, status word and the configuration word read 0, `ctrl_en_o` is 0 and `irq_o` is 0.
- R2: An event pulse sets its status bit only when the matching latch-mask bit is 1. Once set, the bit holds until it is cleared.
- R3: A status bit contributes to `irq_o` only when its signal-mask bit is 1.
- R4: A write to the clear word clears each status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: Configuration bit 1 is the interrupt enable. While it is 0, `irq_o` stays low but status still latches. Setting it to 1 with a signalled bit pending raises `irq_o` one cycle later.
- R6: A suspended event (status bit 1) latches when its latch-mask bit is 1, even while its signal-mask bit is 0, and it then leaves `irq_o` low.
- R7: Configuration bit 0 is the controller enable. It drives `ctrl_en_o` and reads back. It has no effect on latching or on `irq_o`.
- R8: A latch mask of all zeros stops every event of that channel from setting status.
- R9: The status bits are: bit 0 transfer done, bit 1 suspended, bits 8 to 15 error classes 0 to 7. Bits 2 to 7 and 16 to 31 of the masks and of status always read 0, and writes to them are ignored.
- R10: If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R11: `irq_o` is registered. It changes on the clock edge after the edge that changes status or a mask.
- R12: `irq_o` is the OR over all channels. It stays high while any channel still has a signalled bit pending.
- R13: The register map is as follows. Configuration is at 0x00. Channel c has its base at 0x10*(c+1), with the latch mask at +0x0, the signal mask at +0x4, status at +0x8 and clear at +0xC. Writes to the status word have no effect, and the clear word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| ev_done | input | NUM_CH | Transfer-done pulse per channel |
| ev_susp | input | NUM_CH | Suspended pulse per channel |
| ev_err | input | NUM_CH*8 | Error-class pulses, 8 per channel |
| ctrl_en_o | output | 1 | Controller enable bit |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is an event that lands in the same clock cycle as a clear write to its own bit. The bench drives the event pulse and the clear strobe from one negative edge, so that both meet at the same rising edge. It then reads status to confirm the bit survived. It also times the interrupt edges against the write that changes a mask or the enable. The bench checks that `irq_o` is still low right after the committing edge and high one cycle later. This separates the registered output from a combinational one.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int STAT_W   = 16;
  localparam int DONE_BIT = 0;
  localparam int SUSP_BIT = 1;
  localparam int ERR_LSB  = 8;
  localparam int ERR_W    = 8;
  localparam logic [STAT_W-1:0] IMPL_MASK = 16'hFF03;

  typedef enum logic [1:0] {
    OFS_LATCH = 2'd0,
    OFS_SIGNAL = 2'd1,
    OFS_STATUS = 2'd2,
    OFS_CLEAR = 2'd3
  } ofs_e;

  typedef struct packed {
    logic irq_en;
    logic ctrl_en;
  } cfg_t;
endpackage

// File: rtl/dic_rst_sync.sv
module dic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dic_decode.sv
module dic_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              cfg_hit,
  output logic [NUM_CH-1:0] ch_hit,
  output dic_pkg::ofs_e     ofs,
  output logic              cfg_we,
  output logic [NUM_CH-1:0] latch_we,
  output logic [NUM_CH-1:0] signal_we,
  output logic [NUM_CH-1:0] clear_we
);
  import dic_pkg::*;
  localparam int BLK_W = ADDR_W - 4;

  logic             aligned;
  logic [BLK_W-1:0] blk;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign blk     = bus_addr[ADDR_W-1:4];
  assign ofs     = ofs_e'(bus_addr[3:2]);
  assign cfg_hit = aligned && (blk == '0) && (ofs == OFS_LATCH);
  assign cfg_we  = bus_wr && cfg_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_hit[c]    = aligned && (blk == BLK_W'(c + 1));
    assign latch_we[c]  = bus_wr && ch_hit[c] && (ofs == OFS_LATCH);
    assign signal_we[c] = bus_wr && ch_hit[c] && (ofs == OFS_SIGNAL);
    assign clear_we[c]  = bus_wr && ch_hit[c] && (ofs == OFS_CLEAR);
  end
endmodule

// File: rtl/dic_chan_status.sv
module dic_chan_status #(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       latch_we,
  input  logic                       signal_we,
  input  logic                       clear_we,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [dic_pkg::STAT_W-1:0] ev,
  output logic [dic_pkg::STAT_W-1:0] latch_q,
  output logic [dic_pkg::STAT_W-1:0] signal_q,
  output logic [dic_pkg::STAT_W-1:0] stat_q,
  output logic                       pend
);
  import dic_pkg::*;

  logic [STAT_W-1:0] wd_impl;
  logic [STAT_W-1:0] latch_d, signal_d, stat_d;
  logic [STAT_W-1:0] clr_bits, set_bits;

  assign wd_impl = STAT_W'(wdata) & IMPL_MASK;

  always_comb begin
    latch_d  = latch_q;
    signal_d = signal_q;
    if (latch_we)  latch_d  = wd_impl;
    if (signal_we) signal_d = wd_impl;
    clr_bits = clear_we ? wd_impl : '0;
    set_bits = ev & latch_q & IMPL_MASK;
    stat_d   = (stat_q & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      signal_q <= '0;
      stat_q   <= '0;
    end else begin
      latch_q  <= latch_d;
      signal_q <= signal_d;
      stat_q   <= stat_d;
    end
  end

  assign pend = |(stat_q & signal_q);
endmodule

// File: rtl/dic_irq_out.sv
module dic_irq_out #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend,
  input  logic              irq_en,
  output logic              irq_q
);
  logic irq_d;

  always_comb irq_d = irq_en && (|pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_CH-1:0]         ev_done,
  input  logic [NUM_CH-1:0]         ev_susp,
  input  logic [NUM_CH*8-1:0]       ev_err,
  output logic                      ctrl_en_o,
  output logic                      irq_o
);
  import dic_pkg::*;
  localparam int ALL_W = NUM_CH * STAT_W;

  logic rst_s;
  cfg_t cfg_q, cfg_d;
  logic              cfg_hit, cfg_we;
  logic [NUM_CH-1:0] ch_hit, latch_we, signal_we, clear_we, pend;
  ofs_e              ofs;
  logic [ALL_W-1:0]  ev_all, latch_all, signal_all, stat_all;
  logic [DATA_W-1:0] rd_d, rdata_q;
  logic              irq_en;

  dic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  dic_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .cfg_hit(cfg_hit), .ch_hit(ch_hit),
    .ofs(ofs), .cfg_we(cfg_we), .latch_we(latch_we), .signal_we(signal_we),
    .clear_we(clear_we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ev_all[c*STAT_W +: STAT_W] =
      {ev_err[c*ERR_W +: ERR_W], 6'b0, ev_susp[c], ev_done[c]};

    dic_chan_status #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_s),
      .latch_we(latch_we[c]), .signal_we(signal_we[c]), .clear_we(clear_we[c]),
      .wdata(bus_wdata), .ev(ev_all[c*STAT_W +: STAT_W]),
      .latch_q(latch_all[c*STAT_W +: STAT_W]),
      .signal_q(signal_all[c*STAT_W +: STAT_W]),
      .stat_q(stat_all[c*STAT_W +: STAT_W]),
      .pend(pend[c])
    );
  end

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_t'(bus_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign irq_en    = cfg_q.irq_en;
  assign ctrl_en_o = cfg_q.ctrl_en;

  dic_irq_out #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_s), .pend(pend), .irq_en(irq_en), .irq_q(irq_o)
  );

  always_comb begin
    rd_d = '0;
    if (cfg_hit) rd_d = DATA_W'({cfg_q.irq_en, cfg_q.ctrl_en});
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) begin
        unique case (ofs)
          OFS_LATCH:  rd_d = DATA_W'(latch_all[c*STAT_W +: STAT_W]);
          OFS_SIGNAL: rd_d = DATA_W'(signal_all[c*STAT_W +: STAT_W]);
          OFS_STATUS: rd_d = DATA_W'(stat_all[c*STAT_W +: STAT_W]);
          OFS_CLEAR:  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/dic_chk.sv
module dic_chk #(
  parameter int NUM_CH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_o,
  input logic                 irq_en,
  input logic [NUM_CH*16-1:0] ev_all,
  input logic [NUM_CH*16-1:0] latch_all,
  input logic [NUM_CH*16-1:0] signal_all,
  input logic [NUM_CH*16-1:0] stat_all
);
  localparam logic [NUM_CH*16-1:0] RSV = ~{NUM_CH{16'hFF03}};

  // R2
  new_bit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_all & ~$past(stat_all) & ~$past(ev_all & latch_all)) == '0);

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_all & latch_all) & ~stat_all) == '0);

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_all & RSV) == '0);

  // R5
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_o);

  // R3
  no_pend_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all & signal_all) == '0) |=> !irq_o);

  // R11
  pend_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && ((stat_all & signal_all) != '0)) |=> irq_o);
endmodule

bind dma_irq_ctrl dic_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_s), .irq_o(irq_o), .irq_en(irq_en),
  .ev_all(ev_all), .latch_all(latch_all), .signal_all(signal_all),
  .stat_all(stat_all)
);

// File: tb/sim_dma_irq_ctrl.sv
module sim_dma_irq_ctrl;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0]   ev_done = '0, ev_susp = '0;
  logic [NCH*8-1:0] ev_err = '0;
  logic ctrl_en_o, irq_o;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  dma_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_done(ev_done), .ev_susp(ev_susp), .ev_err(ev_err),
    .ctrl_en_o(ctrl_en_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] a_of(int ch, int ofs);
    return 8'((ch + 1) * 16 + ofs);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [NCH-1:0] d, logic [NCH-1:0] s, logic [NCH*8-1:0] e);
    @(negedge clk);
    ev_done = d; ev_susp = s; ev_err = e;
    @(negedge clk);
    ev_done = '0; ev_susp = '0; ev_err = '0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 ctrl_en", {31'b0, ctrl_en_o}, 0);
    rd(8'h00, 0, "R1 cfg");
    rd(a_of(0, 0), 0, "R1 latch");
    rd(a_of(0, 8), 0, "R1 status");

    // R9 / R13 reserved bits of masks
    wr(a_of(1, 0), 32'hFFFF_FFFF);
    rd(a_of(1, 0), 32'h0000_FF03, "R9 latch reserved");
    // R7 controller enable bit
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h3, "R7 cfg readback");
    check("R7 ctrl_en on", {31'b0, ctrl_en_o}, 1);
    wr(8'h00, 32'h2);
    check("R7 ctrl_en off", {31'b0, ctrl_en_o}, 0);

    // R2 only enabled events latch
    wr(a_of(0, 0), 32'h1);
    pulse(4'b0001, 4'b0001, 32'h0000_0001);
    rd(a_of(0, 8), 32'h1, "R2 status");
    check("R3 no signal mask", {31'b0, irq_o}, 0);

    // R3 / R11 signal mask and latency
    wr(a_of(0, 4), 32'h1);
    check("R11 irq not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R3 irq high (ctrl_en off R7)", {31'b0, irq_o}, 1);

    // R4 write-one-to-clear
    wr(a_of(0, 12), 32'h0);
    rd(a_of(0, 8), 32'h1, "R4 zero write keeps");
    wr(a_of(0, 12), 32'h1);
    check("R11 irq holds one cycle", {31'b0, irq_o}, 1);
    @(negedge clk);
    check("R4 irq low after clear", {31'b0, irq_o}, 0);
    rd(a_of(0, 8), 32'h0, "R4 cleared");

    // R6 suspended polled
    wr(a_of(2, 0), 32'h2);
    pulse('0, 4'b0100, '0);
    rd(a_of(2, 8), 32'h2, "R6 susp latched");
    check("R6 no irq", {31'b0, irq_o}, 0);

    // R8 zero latch mask
    wr(a_of(3, 4), 32'hFFFF);
    pulse(4'b1000, 4'b1000, 32'hFF00_0000);
    rd(a_of(3, 8), 32'h0, "R8 nothing latched");
    check("R8 no irq", {31'b0, irq_o}, 0);

    // R5 global gate
    wr(8'h00, 32'h0);
    wr(a_of(1, 4), 32'hFF00);
    pulse('0, '0, 32'h0000_2000);
    rd(a_of(1, 8), 32'h2000, "R5 latched while gated");
    check("R5 gated low", {31'b0, irq_o}, 0);
    wr(8'h00, 32'h2);
    check("R5 not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R5 irq after enable", {31'b0, irq_o}, 1);

    // R12 OR across channels
    pulse(4'b0001, '0, '0);
    wr(a_of(1, 12), 32'hFF00);
    @(negedge clk);
    check("R12 ch0 keeps irq", {31'b0, irq_o}, 1);
    wr(a_of(0, 12), 32'h1);
    @(negedge clk);
    check("R12 irq low", {31'b0, irq_o}, 0);

    // R10 event wins over clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a_of(0, 12); bus_wdata = 32'h1; ev_done = 4'b0001;
    @(negedge clk);
    bus_wr = 1'b0; ev_done = '0;
    rd(a_of(0, 8), 32'h1, "R10 event wins");

    // R13 status read-only, clear reads 0, misaligned ignored
    wr(a_of(0, 8), 32'h0);
    rd(a_of(0, 8), 32'h1, "R13 status read-only");
    rd(a_of(0, 12), 32'h0, "R13 clear reads 0");
    wr(a_of(0, 13), 32'h1);
    rd(a_of(0, 8), 32'h1, "R13 misaligned ignored");

    repeat (3) @(negedge clk);
    check("R13 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule